// File: doc/BRIEF.md
# Logic Sample Trigger Detector

This block watches a stream of logic-analyzer samples, one channel per bit, and decides when a trigger condition is met. The condition joins a level test with edge tests. The level test compares the masked sample against a reference pattern. The edge tests compare each sample with the last accepted sample. When a valid sample meets the condition, the block raises a one-cycle trigger pulse.

Alongside the live pulse, the block divides the valid samples into back-to-back windows of eight. At the end of each window it reports whether any sample in that window matched, and the position of the earliest match. A capture controller can use this to locate the trigger point to the exact sample when the coarse trigger path lags.

Two configuration profiles are supported. In the normal profile, the level test is active and up to two edge channels may be armed. In the fast profile, the level test is ignored and exactly one edge channel must be armed. Any setup that breaks the rules of its profile raises an error flag and blocks every match.

Top module: `trg_detect`

## Requirements
- R1: In the normal profile, a sample passes the level test when (sample AND cfg_mask) equals cfg_value. With no edge channels armed, passing the level test is enough for a match.
- R2: A channel armed in cfg_rise sees its edge when its bit was 0 in the previous accepted sample and is 1 in the current one.
- R3: A channel armed in cfg_fall sees its edge when its bit was 1 in the previous accepted sample and is 0 in the current one.
- R4: In the normal profile with one or two armed edge channels (bits set in cfg_rise OR cfg_fall), a match needs the level test and at least one armed channel seeing its edge.
- R5: With cfg_fast = 1, the level test is ignored. Exactly one edge channel must be armed, otherwise cfg_err = 1.
- R6: In the normal profile, more than two armed edge channels sets cfg_err = 1. cfg_err is combinational on the configuration inputs. While cfg_err = 1, no sample matches: trig stays low and windows record no hit.
- R7: The previous-sample history resets to 0. It takes the value of every valid sample, matched or not. Samples with smp_valid = 0 neither update the history, nor trigger, nor count toward a window.
- R8: trig is high for exactly the one cycle after the clock edge that accepts a matching valid sample.
- R9: Every eighth valid sample closes a window. win_done pulses in the cycle after it. At the same time, win_hit and win_offset are loaded with whether any sample in the window matched and the 0-based index of the earliest match (0 when none matched). Both then hold until the next window closes.
- R10: After reset, trig, win_done, win_hit and win_offset are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample qualifier |
| smp_data | input | 16 | Logic sample, one bit per channel |
| cfg_value | input | 16 | Level reference pattern |
| cfg_mask | input | 16 | Channels taking part in the level test |
| cfg_rise | input | 16 | Channels armed for a rising edge |
| cfg_fall | input | 16 | Channels armed for a falling edge |
| cfg_fast | input | 1 | Selects the fast profile |
| trig | output | 1 | One-cycle trigger pulse |
| cfg_err | output | 1 | Configuration breaks its profile's rules |
| win_done | output | 1 | A window of eight samples has closed |
| win_hit | output | 1 | The last closed window held a match |
| win_offset | output | 3 | Index of the earliest match in that window |

## Verification
cfg_err depends only on the configuration inputs, so the bench checks it within the same cycle, one time step after driving the configuration. trig, win_done, win_hit and win_offset each sit one register after the accepting clock edge. The bench drives a sample at a falling edge and compares these outputs at the next falling edge. By then, the behavioural reference model has advanced by the same accepted sample. The history of the model changes only on valid samples, so runs of invalid samples between valid ones check that the history and window count are frozen.

// File: rtl/trg_pkg.sv
package trg_pkg;
   typedef enum logic {
      PROF_NORMAL = 1'b0,
      PROF_FAST   = 1'b1
   } prof_e;

   localparam int unsigned TRG_DEF_CH  = 16;
   localparam int unsigned TRG_DEF_WIN = 8;
endpackage

// File: rtl/trg_hist.sv
module trg_hist #(
   parameter int unsigned CH_W = trg_pkg::TRG_DEF_CH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            smp_valid,
   input  logic [CH_W-1:0] smp_data,
   output logic [CH_W-1:0] prev
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         prev <= '0;
      else if (smp_valid) prev <= smp_data;
   end

   // R7: history follows every accepted sample and is frozen otherwise
   a_r7_hist_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $past(smp_valid) |-> prev == $past(smp_data));
   a_r7_hist_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid) |-> $stable(prev));
endmodule

// File: rtl/trg_cond.sv
module trg_cond #(
   parameter int unsigned CH_W      = trg_pkg::TRG_DEF_CH,
   parameter int unsigned MAX_EDGES = 2
) (
   input  logic            [CH_W-1:0] smp_data,
   input  logic            [CH_W-1:0] prev,
   input  logic            [CH_W-1:0] cfg_value,
   input  logic            [CH_W-1:0] cfg_mask,
   input  logic            [CH_W-1:0] cfg_rise,
   input  logic            [CH_W-1:0] cfg_fall,
   input  trg_pkg::prof_e             prof,
   output logic                       match,
   output logic                       cfg_err
);
   localparam int unsigned CNT_W = $clog2(CH_W + 1);

   logic [CH_W-1:0]  armed;
   logic [CH_W-1:0]  seen;
   logic [CNT_W-1:0] n_armed;
   logic             level_ok;
   logic             edge_ok;

   assign armed = cfg_rise | cfg_fall;

   for (genvar i = 0; i < CH_W; i++) begin : g_ch
      assign seen[i] = (cfg_rise[i] & ~prev[i] &  smp_data[i])
                     | (cfg_fall[i] &  prev[i] & ~smp_data[i]);
   end

   always_comb begin
      n_armed = '0;
      for (int i = 0; i < CH_W; i++)
         n_armed = n_armed + CNT_W'(armed[i]);
   end

   always_comb begin
      if (prof == trg_pkg::PROF_FAST) begin
         level_ok = 1'b1;
         cfg_err  = (n_armed != CNT_W'(1));
      end else begin
         level_ok = ((smp_data & cfg_mask) == cfg_value);
         cfg_err  = (n_armed > CNT_W'(MAX_EDGES));
      end
      edge_ok = (armed == '0) | (|seen);
      match   = level_ok & edge_ok & ~cfg_err;
   end
endmodule

// File: rtl/trg_window.sv
module trg_window #(
   parameter int unsigned WIN = trg_pkg::TRG_DEF_WIN
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic                   match,
   output logic                   win_done,
   output logic                   win_hit,
   output logic [$clog2(WIN)-1:0] win_offset
);
   localparam int unsigned OFS_W = $clog2(WIN);
   localparam logic [OFS_W-1:0] LAST = OFS_W'(WIN - 1);

   logic [OFS_W-1:0] cnt;
   logic [OFS_W-1:0] first_idx;
   logic             found;
   logic             nxt_found;
   logic [OFS_W-1:0] nxt_idx;

   always_comb begin
      nxt_found = found | match;
      nxt_idx   = found ? first_idx : (match ? cnt : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         first_idx  <= '0;
         found      <= 1'b0;
         win_done   <= 1'b0;
         win_hit    <= 1'b0;
         win_offset <= '0;
      end else if (smp_valid) begin
         if (cnt == LAST) begin
            win_done   <= 1'b1;
            win_hit    <= nxt_found;
            win_offset <= nxt_found ? nxt_idx : '0;
            cnt        <= '0;
            found      <= 1'b0;
            first_idx  <= '0;
         end else begin
            win_done   <= 1'b0;
            cnt        <= cnt + 1'b1;
            found      <= nxt_found;
            first_idx  <= nxt_idx;
         end
      end else begin
         win_done <= 1'b0;
      end
   end

   // R9: a window closes only on an accepted sample; an empty window reports offset 0
   a_r9_done_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |-> $past(smp_valid));
   a_r9_miss_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !win_hit |-> win_offset == '0);
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      win_done |=> !win_done);
endmodule

// File: rtl/trg_detect.sv
module trg_detect #(
   parameter int unsigned CH_W      = trg_pkg::TRG_DEF_CH,
   parameter int unsigned WIN       = trg_pkg::TRG_DEF_WIN,
   parameter int unsigned MAX_EDGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_valid,
   input  logic [CH_W-1:0]        smp_data,
   input  logic [CH_W-1:0]        cfg_value,
   input  logic [CH_W-1:0]        cfg_mask,
   input  logic [CH_W-1:0]        cfg_rise,
   input  logic [CH_W-1:0]        cfg_fall,
   input  logic                   cfg_fast,
   output logic                   trig,
   output logic                   cfg_err,
   output logic                   win_done,
   output logic                   win_hit,
   output logic [$clog2(WIN)-1:0] win_offset
);
   initial begin
      assert (CH_W >= 1 && CH_W <= 1024) else $error("CH_W out of range");
      assert (WIN >= 2 && (WIN & (WIN - 1)) == 0) else $error("WIN must be a power of two >= 2");
      assert (MAX_EDGES >= 1 && MAX_EDGES <= CH_W) else $error("MAX_EDGES out of range");
   end

   logic [CH_W-1:0] prev;
   logic            match;
   trg_pkg::prof_e  prof;

   assign prof = trg_pkg::prof_e'(cfg_fast);

   trg_hist #(.CH_W(CH_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .smp_data (smp_data),
      .prev     (prev)
   );

   trg_cond #(.CH_W(CH_W), .MAX_EDGES(MAX_EDGES)) u_cond (
      .smp_data (smp_data),
      .prev     (prev),
      .cfg_value(cfg_value),
      .cfg_mask (cfg_mask),
      .cfg_rise (cfg_rise),
      .cfg_fall (cfg_fall),
      .prof     (prof),
      .match    (match),
      .cfg_err  (cfg_err)
   );

   trg_window #(.WIN(WIN)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .match     (match),
      .win_done  (win_done),
      .win_hit   (win_hit),
      .win_offset(win_offset)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig <= 1'b0;
      else        trig <= smp_valid & match;
   end

   // R8: pulse follows an accepted sample
   a_r8_trig_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> $past(smp_valid));
   // R6: an erroneous configuration never fires
   a_r6_no_trig_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> !$past(cfg_err));
endmodule

// File: tb/trg_detect_test.sv
module trg_detect_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic [15:0] cfg_value = '0, cfg_mask = '0, cfg_rise = '0, cfg_fall = '0;
   logic        cfg_fast = 1'b0;
   logic        trig, cfg_err, win_done, win_hit;
   logic [2:0]  win_offset;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model state
   logic [15:0] m_prev = '0;
   int          m_cnt = 0;
   int          m_first = -1;
   bit          e_trig = 0, e_done = 0, e_hit = 0;
   int          e_off = 0;

   always #2 clk = ~clk;

   trg_detect uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_rise(cfg_rise),
      .cfg_fall(cfg_fall), .cfg_fast(cfg_fast), .trig(trig), .cfg_err(cfg_err),
      .win_done(win_done), .win_hit(win_hit), .win_offset(win_offset)
   );

   task automatic cmp(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit ref_err();
      int n = 0;
      for (int i = 0; i < 16; i++) if (cfg_rise[i] || cfg_fall[i]) n++;
      return cfg_fast ? (n != 1) : (n > 2);
   endfunction

   function automatic bit ref_match(logic [15:0] d);
      bit lvl, any_armed, any_edge;
      lvl = cfg_fast ? 1'b1 : ((d & cfg_mask) == cfg_value);
      any_armed = 0;
      any_edge = 0;
      for (int i = 0; i < 16; i++) begin
         if (cfg_rise[i] || cfg_fall[i]) any_armed = 1;
         if (cfg_rise[i] && !m_prev[i] && d[i]) any_edge = 1;
         if (cfg_fall[i] && m_prev[i] && !d[i]) any_edge = 1;
      end
      return lvl && (!any_armed || any_edge) && !ref_err();
   endfunction

   task automatic setcfg(logic [15:0] v, logic [15:0] m, logic [15:0] r,
                         logic [15:0] f, logic fast);
      cfg_value = v; cfg_mask = m; cfg_rise = r; cfg_fall = f; cfg_fast = fast;
   endtask

   // One cycle: drive at a falling edge, check cfg_err, then check registered outputs next falling edge
   task automatic cyc(string tag, logic v, logic [15:0] d);
      bit mt;
      smp_valid = v;
      smp_data  = d;
      #1;
      cmp(tag, "cfg_err", cfg_err, ref_err());
      mt = v && ref_match(d);
      e_trig = mt;
      e_done = 0;
      if (v) begin
         if (m_first < 0 && mt) m_first = m_cnt;
         m_cnt++;
         if (m_cnt == 8) begin
            e_done = 1;
            e_hit  = (m_first >= 0);
            e_off  = (m_first >= 0) ? m_first : 0;
            m_cnt = 0;
            m_first = -1;
         end
         m_prev = d;
      end
      @(negedge clk);
      cmp(tag, "trig", trig, e_trig);
      cmp("R9", "win_done", win_done, e_done);
      cmp("R9", "win_hit", win_hit, e_hit);
      cmp("R9", "win_offset", win_offset, e_off);
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R10: reset state
      cmp("R10", "trig", trig, 0);
      cmp("R10", "win_done", win_done, 0);
      cmp("R10", "win_hit", win_hit, 0);
      cmp("R10", "win_offset", win_offset, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: level only
      setcfg(16'h0012, 16'h00FF, 16'h0, 16'h0, 1'b0);
      cyc("R1", 1, 16'h3412);
      cyc("R1", 1, 16'h3413);
      cyc("R1", 1, 16'hAB12);
      cyc("R1", 0, 16'hAB12);

      // R2: rising edge, mask empty
      setcfg(16'h0, 16'h0, 16'h0004, 16'h0, 1'b0);
      cyc("R2", 1, 16'h0000);
      cyc("R2", 1, 16'h0004);
      cyc("R2", 1, 16'h0004);
      cyc("R2", 1, 16'h0000);
      cyc("R2", 1, 16'hFFFF);

      // R3: falling edge
      setcfg(16'h0, 16'h0, 16'h0, 16'h8000, 1'b0);
      cyc("R3", 1, 16'h8000);
      cyc("R3", 1, 16'h0000);
      cyc("R3", 1, 16'h0000);
      cyc("R3", 1, 16'h8001);

      // R4: two armed channels ORed, ANDed with level
      setcfg(16'hA000, 16'hF000, 16'h0001, 16'h0010, 1'b0);
      cyc("R4", 1, 16'hA010);
      cyc("R4", 1, 16'hA000);
      cyc("R4", 1, 16'hA001);
      cyc("R4", 1, 16'hB000);
      cyc("R4", 1, 16'hB001);
      cyc("R4", 1, 16'hA011);

      // R6: three armed channels -> error, nothing fires
      setcfg(16'h0, 16'h0, 16'h0007, 16'h0, 1'b0);
      cyc("R6", 1, 16'h0000);
      cyc("R6", 1, 16'h0007);
      cyc("R6", 1, 16'h0000);
      cyc("R6", 1, 16'h0007);

      // R5: fast profile, level ignored, single channel
      setcfg(16'h1234, 16'hFFFF, 16'h0002, 16'h0, 1'b1);
      cyc("R5", 1, 16'h0000);
      cyc("R5", 1, 16'h0002);
      cyc("R5", 1, 16'h0000);
      setcfg(16'h0, 16'h0, 16'h0002, 16'h0001, 1'b1);
      cyc("R5", 1, 16'h0002);
      setcfg(16'h0, 16'h0, 16'h0, 16'h0, 1'b1);
      cyc("R5", 1, 16'h0000);

      // R7: invalid samples do not move history
      setcfg(16'h0, 16'h0, 16'h0040, 16'h0, 1'b0);
      cyc("R7", 1, 16'h0000);
      cyc("R7", 0, 16'h0040);
      cyc("R7", 0, 16'h0040);
      cyc("R7", 1, 16'h0040);
      setcfg(16'h0001, 16'h0001, 16'h0, 16'h0, 1'b0);
      cyc("R7", 1, 16'h0000);
      setcfg(16'h0, 16'h0, 16'h0, 16'h0001, 1'b0);
      cyc("R7", 1, 16'h0000);

      // R8 / R9: pseudo-random stream with mixed configurations
      lfsr = 16'hACE1;
      for (int k = 0; k < 600; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (k % 100 == 0) begin
            case ((k / 100) % 6)
               0: setcfg(16'h0003, 16'h0003, 16'h0, 16'h0, 1'b0);
               1: setcfg(16'h0, 16'h0, 16'h0010, 16'h0, 1'b0);
               2: setcfg(16'h0001, 16'h0001, 16'h0100, 16'h0200, 1'b0);
               3: setcfg(16'h0, 16'h0, 16'h0, 16'h0008, 1'b1);
               4: setcfg(16'h0, 16'h0, 16'h0111, 16'h0, 1'b0);
               default: setcfg(16'h0000, 16'h0000, 16'h0, 16'h0, 1'b0);
            endcase
         end
         cyc("R8", lfsr[0] | lfsr[5], lfsr ^ {lfsr[7:0], lfsr[15:8]});
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule